// File: doc/BRIEF.md
# Private Countdown Timer

This block is a word-addressed countdown timer of the kind each processor core in a multi-core cluster owns. A divider set by software scales the input clock. A 32-bit counter steps down once per scaled tick. When the count runs out, a sticky status bit is raised. The timer then either stops at zero (single-shot) or refills from a stored start value and keeps going (periodic). Software reaches four word registers through a plain write strobe, a byte address and a combinational read path. An interrupt controller watches the block through two outputs: a level that mirrors the status bit, and a one-cycle pulse when that bit rises.

A three-state machine sets the counting behaviour. In ST_OFF the enable bit is clear and the count is frozen. In ST_HOLD the timer is enabled but the count is zero, so nothing moves. In ST_RUN the timer is enabled with a non-zero count and steps down on each divider tick. The transitions are:
- EN_ON_IDLE: ST_OFF to ST_HOLD, on enabling with a zero count.
- EN_ON_RUN: ST_OFF to ST_RUN, on enabling with a non-zero count, including a count just refilled on enable.
- ARM: ST_HOLD to ST_RUN, when a write or refill gives a non-zero count.
- EXPIRE_STOP: ST_RUN to ST_HOLD, when the count reaches zero in single-shot mode or reloads zero.
- EN_OFF: ST_HOLD or ST_RUN to ST_OFF, on clearing the enable bit.

Periodic refill stays in ST_RUN.

Top module: `prv_timer`

## Requirements
- R1: After reset, all four registers read 0 and both interrupt outputs are 0. The registers are selected by address bits 3:2: 0x0 start value, 0x4 live count, 0x8 control, 0xC status.
- R2: The control register stores and reads back all 32 bits. Bit 0 enables counting, bit 1 selects periodic refill, and bits 15:8 hold the divider value P.
- R3: While running, the count drops by one every P+1 clocks. A count N written or enabled at clock edge E expires at edge E+N*(P+1).
- R4: A write to 0x0 sets both the start value and the live count. A write to 0x4 sets only the live count.
- R5: A live-count write while enabled restarts the countdown from the new value with the divider phase reset to zero.
- R6: In single-shot mode, expiry sets status bit 0 and leaves the count stopped at zero.
- R7: In periodic mode, expiry sets status bit 0 and refills the count from the start value on the same edge, and counting continues.
- R8: When the enable bit goes from 0 to 1 with a zero count and periodic mode selected, the count is first refilled from the start value.
- R9: Reading 0x4 returns 0 while the timer is disabled or the count is zero. Otherwise it returns the live count.
- R10: Writing 0xC clears status bit 0 when data bit 0 is 1 and leaves it unchanged otherwise. Status bits 31:1 read as 0.
- R11: irq_level equals status bit 0. irq_pulse is high for exactly the one cycle after status bit 0 rises, and does not repeat while the bit stays set.
- R12: Enabled with a zero count, the timer holds at zero and never sets the status bit.
- R13: While disabled, the live count keeps its value, and that value resumes when the timer is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address, bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_level | output | 1 | Level interrupt, equal to the status bit |
| irq_pulse | output | 1 | One-cycle pulse on a rising status bit |

## Verification
The hardest situation to reach from the ports is a live-count rewrite that lands on the very edge where the divider would otherwise have ticked. The stimulus enables the timer with a divider of 3 and waits a counted number of idle cycles. It then issues the rewrite so that it commits exactly on that tick edge. The bench then checks the expiry edge to the cycle: 20 clocks after the rewrite, neither 19 nor 21. This exposes any stale divider phase or decrement leaking into the restart. Periodic refill is also observed across a status clear, to confirm the second rising edge produces a fresh pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        REG_START = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_STAT  = 2'd3
    } tmr_reg_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_AUTO_BIT = 1;
    localparam int CTRL_DIV_LSB  = 8;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;

    // >= keeps the divider safe if the division value is lowered mid-count
    assign tick_o = run_i && !restart_i && (phase_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= tick_o ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_next_i,
    input  logic       zero_next_i,
    output tmr_state_e state_o
);
    tmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_next_i) state_d = zero_next_i ? ST_HOLD : ST_RUN; // EN_ON_IDLE / EN_ON_RUN
            end
            ST_HOLD: begin
                if (!en_next_i)        state_d = ST_OFF;   // EN_OFF
                else if (!zero_next_i) state_d = ST_RUN;   // ARM
            end
            ST_RUN: begin
                if (!en_next_i)       state_d = ST_OFF;    // EN_OFF
                else if (zero_next_i) state_d = ST_HOLD;   // EXPIRE_STOP
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  tmr_state_e        state_i,
    input  logic              tick_i,
    output logic              restart_o,
    output logic              en_next_o,
    output logic              zero_next_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              irq_level,
    output logic              irq_pulse
);
    logic [DATA_W-1:0] start_q, start_d;
    logic [DATA_W-1:0] count_q, count_d;
    logic [DATA_W-1:0] ctrl_q,  ctrl_d;
    logic              stat_q,  stat_d, stat_prev_q;
    logic              expire;
    tmr_reg_e          sel;

    assign sel = tmr_reg_e'(bus_addr[3:2]);

    always_comb begin
        start_d   = start_q;
        count_d   = count_q;
        ctrl_d    = ctrl_q;
        stat_d    = stat_q;
        restart_o = 1'b0;
        expire    = 1'b0;
        if (tick_i) begin
            if (count_q == DATA_W'(1)) begin
                expire  = 1'b1;
                count_d = ctrl_q[CTRL_AUTO_BIT] ? start_q : '0;
            end else begin
                count_d = count_q - 1'b1;
            end
        end
        if (bus_wr) begin
            unique case (sel)
                REG_START: begin
                    start_d   = bus_wdata;
                    count_d   = bus_wdata;
                    restart_o = 1'b1;
                end
                REG_COUNT: begin
                    count_d   = bus_wdata;
                    restart_o = 1'b1;
                end
                REG_CTRL: begin
                    ctrl_d = bus_wdata;
                    if (!ctrl_q[CTRL_EN_BIT] && bus_wdata[CTRL_EN_BIT]) begin
                        restart_o = 1'b1;
                        if (count_q == '0 && bus_wdata[CTRL_AUTO_BIT]) count_d = start_q;
                    end
                end
                REG_STAT: begin
                    if (bus_wdata[0]) stat_d = 1'b0;
                end
                default: ;
            endcase
        end
        if (expire) stat_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q     <= '0;
            count_q     <= '0;
            ctrl_q      <= '0;
            stat_q      <= 1'b0;
            stat_prev_q <= 1'b0;
        end else begin
            start_q     <= start_d;
            count_q     <= count_d;
            ctrl_q      <= ctrl_d;
            stat_q      <= stat_d;
            stat_prev_q <= stat_q;
        end
    end

    always_comb begin
        unique case (sel)
            REG_START: bus_rdata = start_q;
            REG_COUNT: bus_rdata = (ctrl_q[CTRL_EN_BIT] && count_q != '0) ? count_q : '0;
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_STAT:  bus_rdata = DATA_W'(stat_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign en_next_o   = ctrl_d[CTRL_EN_BIT];
    assign zero_next_o = (count_d == '0);
    assign div_o       = ctrl_q[CTRL_DIV_LSB +: DIV_W];
    assign irq_level   = stat_q;
    assign irq_pulse   = stat_q && !stat_prev_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R11
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(bus_wr && sel == REG_STAT && bus_wdata[0])) |=> stat_q); // R10
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_HOLD && !bus_wr) |=> (count_q == '0 && !$rose(stat_q))); // R12
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_OFF && !bus_wr) |=> $stable(count_q)); // R13
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_q[CTRL_AUTO_BIT] && !bus_wr) |=> (count_q == '0 && stat_q)); // R6
    AST_AUTO_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q[CTRL_AUTO_BIT] && !bus_wr) |=> (count_q == $past(start_q) && stat_q)); // R7
endmodule

// File: rtl/prv_timer.sv
module prv_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_level,
    output logic              irq_pulse
);
    tmr_state_e       state;
    logic             tick, restart, en_next, zero_next;
    logic [DIV_W-1:0] div;

    tmr_core #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .state_i    (state),
        .tick_i     (tick),
        .restart_o  (restart),
        .en_next_o  (en_next),
        .zero_next_o(zero_next),
        .div_o      (div),
        .irq_level  (irq_level),
        .irq_pulse  (irq_pulse)
    );

    tmr_prescale #(.DIV_W(DIV_W)) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state == ST_RUN),
        .restart_i(restart),
        .div_i    (div),
        .tick_o   (tick)
    );

    tmr_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_next_i  (en_next),
        .zero_next_i(zero_next),
        .state_o    (state)
    );
endmodule

// File: tb/prv_timer_tb_top.sv
module prv_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_level, irq_pulse;
    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_START = 4'h0, A_COUNT = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;

    typedef struct packed {
        logic [31:0] n;
        logic [7:0]  p;
        logic [31:0] cyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'd3, 8'd0,   32'd3},
        '{32'd1, 8'd0,   32'd1},
        '{32'd2, 8'd4,   32'd10},
        '{32'd5, 8'd2,   32'd15},
        '{32'd4, 8'd7,   32'd32},
        '{32'd1, 8'd255, 32'd256}
    };

    always #2.5 clk = ~clk;

    prv_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_START, v); check("R1 start", v, 0);
        rd(A_COUNT, v); check("R1 count", v, 0);
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_STAT, v);  check("R1 stat", v, 0);
        check("R1 irq", {irq_level, irq_pulse}, 0);

        // R2 full control readback
        wr(A_CTRL, 32'hABCD_12FC);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 32'hABCD_12FC);
        wr(A_CTRL, 0);

        // R3 table-driven expiry timing (single-shot)
        foreach (VECS[k]) begin
            wr(A_CTRL, 0);
            wr(A_STAT, 1);
            wr(A_START, VECS[k].n);
            wr(A_CTRL, {16'd0, VECS[k].p, 8'h01});
            wait_cyc(int'(VECS[k].cyc) - 1);
            rd(A_COUNT, v); check("R3 count before expiry", v, 1);
            check("R3 stat before expiry", {31'd0, irq_level}, 0);
            @(negedge clk);
            check("R3 stat at expiry", {31'd0, irq_level}, 1);
            check("R11 pulse at expiry", {31'd0, irq_pulse}, 1);
            rd(A_COUNT, v); check("R6 count zero at expiry", v, 0);
        end
        wait_cyc(10);
        check("R11 no repeat pulse", {31'd0, irq_pulse}, 0);
        check("R6 status stays set", {31'd0, irq_level}, 1);

        // R4 / R9 / R13
        wr(A_CTRL, 0);
        wr(A_START, 7);
        wr(A_COUNT, 9);
        rd(A_START, v); check("R4 count write keeps start", v, 7);
        rd(A_COUNT, v); check("R9 disabled reads zero", v, 0);
        wr(A_CTRL, 32'h0000_FF01);
        rd(A_COUNT, v); check("R4 count write value", v, 9);
        wr(A_CTRL, 32'h0000_FF00);
        wait_cyc(20);
        wr(A_CTRL, 32'h0000_FF01);
        rd(A_COUNT, v); check("R13 frozen while disabled", v, 9);

        // R5 restart aligned with a pending divider tick
        wr(A_CTRL, 0);
        wr(A_STAT, 1);
        wr(A_COUNT, 10);
        wr(A_CTRL, 32'h0000_0301);
        wait_cyc(2);
        wr(A_COUNT, 5);
        wait_cyc(19);
        check("R5 no expiry at 19", {31'd0, irq_level}, 0);
        rd(A_COUNT, v); check("R5 count at 19", v, 1);
        @(negedge clk);
        check("R5 expiry at 20", {31'd0, irq_level}, 1);

        // R7 periodic refill
        wr(A_CTRL, 0);
        wr(A_STAT, 1);
        wr(A_START, 3);
        wr(A_CTRL, 32'h0000_0003);
        wait_cyc(3);
        check("R7 first expiry", {31'd0, irq_level}, 1);
        rd(A_COUNT, v); check("R7 refilled", v, 3);
        wr(A_STAT, 1);
        check("R10 cleared", {31'd0, irq_level}, 0);
        rd(A_COUNT, v); check("R7 keeps counting", v, 1);
        @(negedge clk);
        check("R7 second expiry", {31'd0, irq_level}, 1);
        check("R11 second pulse", {31'd0, irq_pulse}, 1);

        // R8 refill on enable with zero count
        wr(A_CTRL, 0);
        wr(A_STAT, 1);
        wr(A_START, 4);
        wr(A_COUNT, 0);
        wr(A_CTRL, 32'h0000_0003);
        rd(A_COUNT, v); check("R8 refill on enable", v, 4);
        wait_cyc(3);
        check("R8 no early expiry", {31'd0, irq_level}, 0);
        @(negedge clk);
        check("R8 expiry", {31'd0, irq_level}, 1);

        // R10 write-one-to-clear
        wr(A_CTRL, 0);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); check("R10 zero bit keeps status", v, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R10 one bit clears", v, 0);

        // R12 enabled with zero count holds
        wr(A_COUNT, 0);
        wr(A_CTRL, 32'h0000_0001);
        wait_cyc(30);
        check("R12 no status", {31'd0, irq_level}, 0);
        rd(A_COUNT, v); check("R12 count zero", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule